// File: doc/BRIEF.md
# Tagged-Status Infrared Byte FIFO Pair

This block sits between the line coder of a fast infrared port and the processor's register bus. Received bytes arrive on a valid/data interface together with end-of-frame and CRC-error markers. Each byte is stored in a receive queue together with a three-bit status tag. Software can inspect the head entry's tag before it reads the byte. Reading the data register pops the byte and its tag together. A transmit queue, filled through the same data register, drains onto a valid/ready byte stream. That stream carries a last-byte marker, which software sets by writing through a second data address.

The receive side raises a service request when its fill level reaches a programmable threshold. It also raises a summary flag while any stored entry carries a tag. Live flags report receive-not-empty, transmit-not-full and transmitter-busy. Sticky flags record a framing error, a receiver abort and a transmit underrun, and each is cleared by writing one to it. A loopback mode feeds transmitted bytes straight back into the receive queue. A single registered interrupt line combines the receive and transmit requests under their enable bits.

Register map (3-bit address): 0 control, 1 threshold, 2 data, 3 data-with-last-marker (write only), 4 event status, 5 live status. Reads return data in `reg_rdata` on the cycle after `reg_rd`, and the value is held until the next read.

Top module: `irf_port`

## Requirements
- R1: After reset the control and threshold registers read 0, the event status reads 0x04 (only transmit request set), the live status reads 0x02 (only transmit-not-full set), `irq` is 0 and `tx_valid` is 0.
- R2: With receive enable (control bit 0) set and loopback clear, each `rx_valid` cycle stores `rx_byte`. Reads of address 2 return the stored bytes in arrival order, one per read, and each read removes one entry.
- R3: Live status bits 5:3 show the head entry's tag as {overrun, CRC error, end of frame} without removing it. The next read of address 2 removes the byte and its tag together.
- R4: Event status bit 1 (receive request) is high when the receive level is at least 8, 16 or 32 for threshold values 0, 1 or 2 respectively, and at least 32 for value 3.
- R5: Event status bit 0 is high exactly while at least one stored receive entry has any tag bit set.
- R6: The receive queue holds 64 entries. A byte arriving when it is full, with no pop in the same cycle, is discarded, and the overrun tag of the newest stored entry is set.
- R7: A read of address 2 with an empty receive queue returns 0 and removes nothing. A byte stored afterwards is the next one returned.
- R8: Writes to address 2 and address 3 queue bytes for transmit, and address 3 marks the byte as last. With transmit enable (control bit 1) set, the bytes leave in order on `tx_valid`/`tx_byte`/`tx_last`, and `tx_byte` is held while `tx_ready` is low. With transmit enable clear, nothing leaves. Live status bit 1 (transmit-not-full) is low when 64 bytes are queued. Live status bit 2 (busy) stays high until the last byte has been accepted. Event status bit 2 is high while at least 32 transmit slots are free.
- R9: With the underrun-select bit (control bit 5) set, event status bit 3 is set when the transmit queue runs empty after a byte not marked last has left. With that bit clear, this condition sets nothing.
- R10: Event status bits 4 (framing error, set by `rx_frame_err`) and 5 (receiver abort, set by `rx_abort`) stay set until software writes 1 to that bit position at address 4. Bit 3 is cleared the same way. Writing 0 to a bit leaves it unchanged.
- R11: With loopback (control bit 2) set, transmitted bytes enter the receive queue with their last marker as the end-of-frame tag, `tx_valid` stays low, and `rx_valid` is ignored.
- R12: `irq` equals, one cycle later, (receive interrupt enable, control bit 3, AND (receive request OR tag summary)) OR (transmit interrupt enable, control bit 4, AND transmit request).
- R13: With receive enable clear, `rx_valid` stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| rx_valid | input | 1 | Received byte present |
| rx_byte | input | 8 | Received byte |
| rx_eof | input | 1 | Byte ends a frame |
| rx_crc_err | input | 1 | Frame check failed on this byte |
| rx_frame_err | input | 1 | Framing error event pulse |
| rx_abort | input | 1 | Receiver abort event pulse |
| tx_valid | output | 1 | Transmit byte offered |
| tx_byte | output | 8 | Transmit byte |
| tx_last | output | 1 | Offered byte ends the frame |
| tx_ready | input | 1 | Line side accepts the offered byte |
| irq | output | 1 | Registered interrupt request |

## Verification
The embedded properties assume that the loopback bit is not switched while a transmit byte is waiting in the output stage, since such a switch would legitimately drop `tx_valid` under a stalled `tx_ready`. They also assume that event pulses and receive bytes are single synchronous cycles with no X values. The stimulus changes the control word only while the transmit stage is empty, holds every input for exactly one clock, and drives everything one nanosecond after the rising edge.

// File: rtl/irf_pkg.sv
`timescale 1ns/1ps
package irf_pkg;
  // receive tag bit positions
  localparam int TAG_W   = 3;
  localparam int TAG_EOF = 0;
  localparam int TAG_CRC = 1;
  localparam int TAG_OVR = 2;

  // control word bit positions
  localparam int CB_RX_EN = 0;
  localparam int CB_TX_EN = 1;
  localparam int CB_LOOP  = 2;
  localparam int CB_RIE   = 3;
  localparam int CB_TIE   = 4;
  localparam int CB_TUS   = 5;
  localparam int CTRL_W   = 6;

  // event status bit positions
  localparam int SB_UNDER = 3;
  localparam int SB_FERR  = 4;
  localparam int SB_ABORT = 5;

  typedef enum logic [2:0] {
    A_CTRL      = 3'd0,
    A_THR       = 3'd1,
    A_DATA      = 3'd2,
    A_DATA_LAST = 3'd3,
    A_STAT0     = 3'd4,
    A_STAT1     = 3'd5
  } irf_addr_e;
endpackage

// File: rtl/irf_rx_fifo.sv
`timescale 1ns/1ps
module irf_rx_fifo
  import irf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [7:0]        push_byte,
  input  logic [TAG_W-1:0]  push_tag,
  input  logic              pop,
  output logic [7:0]        rd_byte,
  output logic [TAG_W-1:0]  head_tag,
  output logic [AW:0]       level,
  output logic              any_tagged
);
  localparam int CW = AW + 1;

  logic [7:0]       mem_q  [DEPTH];
  logic [TAG_W-1:0] tags_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q, last_ptr;
  logic [CW-1:0]    count_q, tcount_q;
  logic             full, accept, ovr_hit, ovr_new, pop_tagged;

  always_comb begin
    full       = (count_q == CW'(DEPTH));
    accept     = push && (!full || pop);
    ovr_hit    = push && full && !pop;
    last_ptr   = wr_ptr_q - AW'(1);
    ovr_new    = ovr_hit && (tags_q[last_ptr] == '0);
    pop_tagged = pop && (tags_q[rd_ptr_q] != '0);
  end

  // data storage: synchronous write, synchronous read on pop
  always_ff @(posedge clk) begin
    if (accept) mem_q[wr_ptr_q] <= push_byte;
    if (pop)    rd_byte         <= mem_q[rd_ptr_q];
  end

  // tag storage kept in registers so the newest entry can be re-tagged
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) tags_q[i] <= '0;
    end else if (accept) begin
      tags_q[wr_ptr_q] <= push_tag;
    end else if (ovr_hit) begin
      tags_q[last_ptr][TAG_OVR] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      tcount_q <= '0;
    end else begin
      if (accept) wr_ptr_q <= wr_ptr_q + AW'(1);
      if (pop)    rd_ptr_q <= rd_ptr_q + AW'(1);
      count_q  <= count_q + CW'(accept) - CW'(pop);
      tcount_q <= tcount_q + CW'(accept && (push_tag != '0)) + CW'(ovr_new)
                  - CW'(pop_tagged);
    end
  end

  assign head_tag   = (count_q != '0) ? tags_q[rd_ptr_q] : '0;
  assign level      = count_q;
  assign any_tagged = (tcount_q != '0);

  AST_RX_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    count_q <= CW'(DEPTH));                                         // R6
  AST_RX_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count_q != '0));                                       // R7
  AST_RX_TAGGED_BOUND: assert property (@(posedge clk) disable iff (rst)
    tcount_q <= count_q);                                           // R5
  AST_RX_OVR_DROPS: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> $stable(count_q) && any_tagged);     // R6
endmodule

// File: rtl/irf_tx_fifo.sv
`timescale 1ns/1ps
module irf_tx_fifo #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        push,
  input  logic [7:0]  push_byte,
  input  logic        push_last,
  input  logic        pop,
  output logic [7:0]  out_byte,
  output logic        out_last,
  output logic [AW:0] level
);
  localparam int CW = AW + 1;

  logic [8:0]    mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic          accept;

  assign accept = push && (count_q != CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (accept) mem_q[wr_ptr_q] <= {push_last, push_byte};
    if (pop)    {out_last, out_byte} <= mem_q[rd_ptr_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (accept) wr_ptr_q <= wr_ptr_q + AW'(1);
      if (pop)    rd_ptr_q <= rd_ptr_q + AW'(1);
      count_q <= count_q + CW'(accept) - CW'(pop);
    end
  end

  assign level = count_q;

  AST_TX_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count_q != '0));                                       // R8
  AST_TX_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    count_q <= CW'(DEPTH));                                         // R8
endmodule

// File: rtl/irf_port.sv
`timescale 1ns/1ps
module irf_port
  import irf_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       rx_eof,
  input  logic       rx_crc_err,
  input  logic       rx_frame_err,
  input  logic       rx_abort,
  output logic       tx_valid,
  output logic [7:0] tx_byte,
  output logic       tx_last,
  input  logic       tx_ready,
  output logic       irq
);
  localparam int AW        = $clog2(DEPTH);
  localparam int CW        = AW + 1;
  localparam int TRIG_BASE = DEPTH / 8;
  localparam int TX_HALF   = DEPTH / 2;

  logic [CTRL_W-1:0] ctrl_q;
  logic [1:0]        thr_q;
  logic              rx_en, tx_en, loop_en, rie, tie, tus;
  logic              w_ctrl, w_thr, w_data, w_last, w_stat0, r_data;

  // receive queue signals
  logic              rx_push, rx_pop, eif;
  logic [7:0]        rx_push_byte, rx_rd_byte;
  logic [TAG_W-1:0]  rx_push_tag, head_tag;
  logic [CW-1:0]     rx_level, trig;
  logic              rx_req;

  // transmit queue and output stage
  logic [CW-1:0]     tx_level;
  logic [7:0]        tx_out_byte;
  logic              tx_out_last;
  logic              st_valid_q, drain, load, in_frame_q, under_evt;
  logic              tx_req, tnf, tbusy;

  // status and read path
  logic              under_q, ferr_q, abort_q;
  logic [7:0]        stat0, stat1, rdata_q;
  logic              data_sel_q, irq_q;

  assign rx_en   = ctrl_q[CB_RX_EN];
  assign tx_en   = ctrl_q[CB_TX_EN];
  assign loop_en = ctrl_q[CB_LOOP];
  assign rie     = ctrl_q[CB_RIE];
  assign tie     = ctrl_q[CB_TIE];
  assign tus     = ctrl_q[CB_TUS];

  always_comb begin
    w_ctrl  = reg_wr && (reg_addr == A_CTRL);
    w_thr   = reg_wr && (reg_addr == A_THR);
    w_data  = reg_wr && (reg_addr == A_DATA);
    w_last  = reg_wr && (reg_addr == A_DATA_LAST);
    w_stat0 = reg_wr && (reg_addr == A_STAT0);
    r_data  = reg_rd && (reg_addr == A_DATA);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      thr_q  <= '0;
    end else begin
      if (w_ctrl) ctrl_q <= reg_wdata[CTRL_W-1:0];
      if (w_thr)  thr_q  <= reg_wdata[1:0];
    end
  end

  // ---------------- transmit path ----------------
  always_comb begin
    drain     = st_valid_q && (loop_en || tx_ready);
    load      = tx_en && (tx_level != '0) && (!st_valid_q || drain);
    under_evt = tx_en && tus && in_frame_q && !st_valid_q && (tx_level == '0);
  end

  irf_tx_fifo #(.DEPTH(DEPTH), .AW(AW)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .push      (w_data || w_last),
    .push_byte (reg_wdata),
    .push_last (w_last),
    .pop       (load),
    .out_byte  (tx_out_byte),
    .out_last  (tx_out_last),
    .level     (tx_level)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_valid_q <= 1'b0;
      in_frame_q <= 1'b0;
    end else begin
      st_valid_q <= load || (st_valid_q && !drain);
      if (drain)          in_frame_q <= !tx_out_last;
      else if (under_evt) in_frame_q <= 1'b0;
    end
  end

  assign tx_valid = st_valid_q && !loop_en;
  assign tx_byte  = tx_out_byte;
  assign tx_last  = tx_out_last;

  // ---------------- receive path ----------------
  always_comb begin
    rx_push      = rx_en && (loop_en ? drain : rx_valid);
    rx_push_byte = loop_en ? tx_out_byte : rx_byte;
    rx_push_tag  = '0;
    rx_push_tag[TAG_EOF] = loop_en ? tx_out_last : rx_eof;
    rx_push_tag[TAG_CRC] = loop_en ? 1'b0 : rx_crc_err;
    rx_pop       = r_data && (rx_level != '0);
  end

  irf_rx_fifo #(.DEPTH(DEPTH), .AW(AW)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .push       (rx_push),
    .push_byte  (rx_push_byte),
    .push_tag   (rx_push_tag),
    .pop        (rx_pop),
    .rd_byte    (rx_rd_byte),
    .head_tag   (head_tag),
    .level      (rx_level),
    .any_tagged (eif)
  );

  always_comb begin
    case (thr_q)
      2'd0:    trig = CW'(TRIG_BASE);
      2'd1:    trig = CW'(TRIG_BASE * 2);
      default: trig = CW'(TRIG_BASE * 4);
    endcase
    rx_req = (rx_level >= trig);
    tx_req = ((CW'(DEPTH) - tx_level) >= CW'(TX_HALF));
    tnf    = (tx_level != CW'(DEPTH));
    tbusy  = st_valid_q || (tx_level != '0);
  end

  // ---------------- sticky events ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      under_q <= 1'b0;
      ferr_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      under_q <= under_evt    || (under_q && !(w_stat0 && reg_wdata[SB_UNDER]));
      ferr_q  <= rx_frame_err || (ferr_q  && !(w_stat0 && reg_wdata[SB_FERR]));
      abort_q <= rx_abort     || (abort_q && !(w_stat0 && reg_wdata[SB_ABORT]));
    end
  end

  assign stat0 = {2'b00, abort_q, ferr_q, under_q, tx_req, rx_req, eif};
  assign stat1 = {2'b00, head_tag[TAG_OVR], head_tag[TAG_CRC], head_tag[TAG_EOF],
                  tbusy, tnf, (rx_level != '0)};

  // ---------------- read port ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q    <= '0;
      data_sel_q <= 1'b0;
    end else if (reg_rd) begin
      data_sel_q <= rx_pop;
      case (irf_addr_e'(reg_addr))
        A_CTRL:  rdata_q <= {{(8-CTRL_W){1'b0}}, ctrl_q};
        A_THR:   rdata_q <= {6'b0, thr_q};
        A_STAT0: rdata_q <= stat0;
        A_STAT1: rdata_q <= stat1;
        default: rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata = data_sel_q ? rx_rd_byte : rdata_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= (rie && (rx_req || eif)) || (tie && tx_req);
  end

  assign irq = irq_q;

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_byte));          // R8
  AST_FERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ferr_q && !(w_stat0 && reg_wdata[SB_FERR])) |=> ferr_q);           // R10
  AST_RX_OFF_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!rx_en && !rx_pop) |=> $stable(rx_level));                         // R13
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!rie && !tie) |=> !irq);                                           // R12
  AST_LOOP_NO_LINE: assert property (@(posedge clk) disable iff (rst)
    (loop_en && $stable(ctrl_q)) |=> !tx_valid);                        // R11
endmodule

// File: tb/irf_port_tb_top.sv
`timescale 1ns/1ps
module irf_port_tb_top;
  localparam logic [2:0] AD_CTRL = 3'd0;
  localparam logic [2:0] AD_THR  = 3'd1;
  localparam logic [2:0] AD_DATA = 3'd2;
  localparam logic [2:0] AD_LAST = 3'd3;
  localparam logic [2:0] AD_ST0  = 3'd4;
  localparam logic [2:0] AD_ST1  = 3'd5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       rx_valid = 1'b0, rx_eof = 1'b0, rx_crc_err = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       rx_frame_err = 1'b0, rx_abort = 1'b0;
  logic       tx_valid, tx_last, irq;
  logic [7:0] tx_byte;
  logic       tx_ready = 1'b0;

  int  vectors = 0;
  int  fails   = 0;
  bit  done    = 1'b0;
  bit  watch_tx = 1'b0;
  bit  seen_tx  = 1'b0;
  int  got;
  logic [7:0] d;

  always #4 clk = ~clk;

  irf_port dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rx_eof(rx_eof), .rx_crc_err(rx_crc_err),
    .rx_frame_err(rx_frame_err), .rx_abort(rx_abort), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .tx_last(tx_last), .tx_ready(tx_ready), .irq(irq)
  );

  always @(negedge clk) if (watch_tx && tx_valid) seen_tx = 1'b1;

  task automatic chk(input string req, input logic [31:0] got_v, input logic [31:0] exp_v);
    vectors++;
    if (got_v !== exp_v) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got_v, exp_v);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] v);
    @(posedge clk); #1 reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(posedge clk); #1 reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); #1 reg_rd = 1'b0; v = reg_rdata;
  endtask

  task automatic rxp(input logic [7:0] b, input logic eof, input logic crc);
    @(posedge clk); #1 rx_valid = 1'b1; rx_byte = b; rx_eof = eof; rx_crc_err = crc;
    @(posedge clk); #1 rx_valid = 1'b0; rx_eof = 1'b0; rx_crc_err = 1'b0;
  endtask

  task automatic settle();
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) settle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1: watchdog expired, got hang expected completion");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // reset state
    rd(AD_CTRL, d); chk("R1 ctrl", 32'(d), 32'h00);
    rd(AD_THR, d);  chk("R1 thr", 32'(d), 32'h00);
    rd(AD_ST0, d);  chk("R1 stat0", 32'(d), 32'h04);
    rd(AD_ST1, d);  chk("R1 stat1", 32'(d), 32'h02);
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 tx_valid", 32'(tx_valid), 32'd0);

    // fill sweep: threshold compare at every level and every setting
    wr(AD_CTRL, 8'h01);
    for (int n = 1; n <= 64; n++) begin
      rxp(8'(n), 1'b0, 1'b0);
      for (int t = 0; t < 4; t++) begin
        wr(AD_THR, 8'(t));
        rd(AD_ST0, d);
        chk("R4 request", 32'(d[1]), 32'(n >= (t == 0 ? 8 : (t == 1 ? 16 : 32))));
      end
      chk("R5 no tag", 32'(d[0]), 32'd0);
    end

    // overflow: dropped byte, overrun on newest entry
    rxp(8'hAA, 1'b1, 1'b0);
    rd(AD_ST0, d); chk("R6 summary after overrun", 32'(d[0]), 32'd1);
    for (int i = 1; i <= 64; i++) begin
      rd(AD_ST1, d);
      chk("R3 head tag", 32'(d[5:3]), (i == 64) ? 32'h4 : 32'h0);
      rd(AD_DATA, d);
      chk("R2 order", 32'(d), 32'(i));
    end
    rd(AD_ST0, d); chk("R5 cleared", 32'(d[0]), 32'd0);
    rd(AD_ST1, d); chk("R6 empty after drain", 32'(d[0]), 32'd0);

    // empty read
    rd(AD_DATA, d); chk("R7 empty read", 32'(d), 32'd0);
    rxp(8'h5C, 1'b0, 1'b0);
    rd(AD_DATA, d); chk("R7 pointers kept", 32'(d), 32'h5C);
    rd(AD_ST1, d);  chk("R7 empty again", 32'(d[0]), 32'd0);

    // tagged entries
    rxp(8'h11, 1'b0, 1'b0);
    rxp(8'h22, 1'b0, 1'b1);
    rxp(8'h33, 1'b1, 1'b0);
    rd(AD_ST0, d);  chk("R5 tagged present", 32'(d[0]), 32'd1);
    rd(AD_ST1, d);  chk("R3 tag plain", 32'(d[5:3]), 32'h0);
    rd(AD_DATA, d); chk("R2 byte 11", 32'(d), 32'h11);
    rd(AD_ST1, d);  chk("R3 tag crc", 32'(d[5:3]), 32'h2);
    rd(AD_ST1, d);  chk("R3 peek does not pop", 32'(d[5:3]), 32'h2);
    rd(AD_DATA, d); chk("R2 byte 22", 32'(d), 32'h22);
    rd(AD_ST0, d);  chk("R5 eof still held", 32'(d[0]), 32'd1);
    rd(AD_ST1, d);  chk("R3 tag eof", 32'(d[5:3]), 32'h1);
    rd(AD_DATA, d); chk("R2 byte 33", 32'(d), 32'h33);
    rd(AD_ST0, d);  chk("R5 all popped", 32'(d[0]), 32'd0);

    // receive disabled
    wr(AD_CTRL, 8'h00);
    rxp(8'h77, 1'b1, 1'b0);
    rd(AD_ST1, d); chk("R13 ignored", 32'(d[0]), 32'd0);
    rd(AD_ST0, d); chk("R13 no tag", 32'(d[0]), 32'd0);

    // transmit: fill while disabled, then drain
    for (int i = 0; i < 64; i++) wr((i == 63) ? AD_LAST : AD_DATA, 8'(i) ^ 8'h5A);
    idle(2);
    chk("R8 held while disabled", 32'(tx_valid), 32'd0);
    rd(AD_ST1, d); chk("R8 full busy flags", 32'(d[2:0]), 32'h4);
    rd(AD_ST0, d); chk("R8 no tx request", 32'(d[2]), 32'd0);
    tx_ready = 1'b1;
    wr(AD_CTRL, 8'h02);
    got = 0;
    for (int c = 0; c < 300 && got < 64; c++) begin
      @(negedge clk);
      if (tx_valid) begin
        chk("R8 byte", 32'(tx_byte), 32'(8'(got) ^ 8'h5A));
        chk("R8 last", 32'(tx_last), 32'(got == 63));
        got++;
      end
    end
    chk("R8 count", 32'(got), 32'd64);
    idle(2);
    rd(AD_ST1, d); chk("R8 idle flags", 32'(d[2:0]), 32'h2);

    // underrun reporting
    wr(AD_CTRL, 8'h22);
    wr(AD_DATA, 8'h10);
    idle(6);
    rd(AD_ST0, d); chk("R9 underrun set", 32'(d[3]), 32'd1);
    wr(AD_ST0, 8'h08);
    rd(AD_ST0, d); chk("R9 underrun cleared", 32'(d[3]), 32'd0);
    wr(AD_CTRL, 8'h02);
    wr(AD_DATA, 8'h11);
    idle(6);
    rd(AD_ST0, d); chk("R9 not reported without select", 32'(d[3]), 32'd0);
    wr(AD_LAST, 8'h12);
    idle(6);
    tx_ready = 1'b0;

    // sticky events
    @(posedge clk); #1 rx_frame_err = 1'b1;
    @(posedge clk); #1 rx_frame_err = 1'b0;
    rd(AD_ST0, d); chk("R10 frame err", 32'(d[5:4]), 32'h1);
    wr(AD_ST0, 8'h20);
    rd(AD_ST0, d); chk("R10 other bit kept", 32'(d[5:4]), 32'h1);
    @(posedge clk); #1 rx_abort = 1'b1;
    @(posedge clk); #1 rx_abort = 1'b0;
    rd(AD_ST0, d); chk("R10 both", 32'(d[5:4]), 32'h3);
    wr(AD_ST0, 8'h10);
    rd(AD_ST0, d); chk("R10 frame cleared", 32'(d[5:4]), 32'h2);
    wr(AD_ST0, 8'h20);
    rd(AD_ST0, d); chk("R10 abort cleared", 32'(d[5:4]), 32'h0);

    // loopback
    seen_tx = 1'b0; watch_tx = 1'b1;
    wr(AD_CTRL, 8'h07);
    wr(AD_DATA, 8'h41);
    wr(AD_DATA, 8'h42);
    rxp(8'h99, 1'b0, 1'b0);
    wr(AD_LAST, 8'h43);
    idle(4);
    watch_tx = 1'b0;
    chk("R11 line quiet", 32'(seen_tx), 32'd0);
    rd(AD_ST1, d);  chk("R11 head tag", 32'(d[5:3]), 32'h0);
    rd(AD_DATA, d); chk("R11 byte 41", 32'(d), 32'h41);
    rd(AD_DATA, d); chk("R11 byte 42", 32'(d), 32'h42);
    rd(AD_ST1, d);  chk("R11 last as eof", 32'(d[5:3]), 32'h1);
    rd(AD_DATA, d); chk("R11 byte 43", 32'(d), 32'h43);
    rd(AD_ST1, d);  chk("R11 external ignored", 32'(d[0]), 32'd0);

    // interrupt combinations
    wr(AD_CTRL, 8'h00); settle();
    chk("R12 off", 32'(irq), 32'd0);
    wr(AD_CTRL, 8'h10); settle();
    chk("R12 tx request", 32'(irq), 32'd1);
    wr(AD_CTRL, 8'h09); settle();
    chk("R12 rx empty", 32'(irq), 32'd0);
    rxp(8'h01, 1'b1, 1'b0); settle();
    chk("R12 tag summary", 32'(irq), 32'd1);
    rd(AD_DATA, d); settle();
    chk("R12 popped", 32'(irq), 32'd0);
    wr(AD_THR, 8'h00);
    for (int k = 1; k <= 8; k++) begin
      rxp(8'(k), 1'b0, 1'b0); settle();
      chk("R12 fill level", 32'(irq), 32'(k >= 8));
    end
    for (int k = 1; k <= 8; k++) rd(AD_DATA, d);
    settle();
    chk("R12 drained", 32'(irq), 32'd0);
    wr(AD_CTRL, 8'h01);
    rxp(8'h02, 1'b1, 1'b0); settle();
    chk("R12 enable off", 32'(irq), 32'd0);
    rd(AD_DATA, d); chk("R2 last byte", 32'(d), 32'h02);

    report();
  end
endmodule